// File: doc/BRIEF.md
# Serial Register Port with Data-Ready Flag

This block is the slave side of a four-wire serial link (select, clock, data in, data out) for a converter-style peripheral. It is clocked by the system clock and oversamples the serial pins. Each access opens with an 8-bit command byte. The byte says whether the next transfer reads or writes, and which internal register it targets. The port then moves that register's bit count and goes back to waiting for a command byte.

The output pin has two jobs. While a read is shifting, it carries the read data. At all other times it shows an active-low flag that falls when a new conversion result has been captured. A host can therefore treat the falling edge of the pin as an interrupt. The result itself arrives on a parallel strobe from the converter core. A continuous mode lets the host take one result after another without sending a command byte before each one.

Top module: `ser_reg_port`

## Requirements
- R1: While `cs_n` is high, `dout_en` is low and serial clock edges have no effect on any register or on frame alignment.
- R2: Every access starts with a command byte, sent MSB first. Bit 7 must be 0, otherwise the byte is discarded and the port waits for another command. Bit 6 is 1 for a read. Bits 5:3 hold the address. Bit 2 requests continuous read. Address map: 0 is an 8-bit read-only status register whose bit 7 is the flag level; 1 is the 16-bit mode register; 2 is the 16-bit config register; 3 is the 24-bit result register; addresses 4 to 7 are 8 bits long and read as zero. Once the addressed length has moved, the port expects a command byte again.
- R3: Write data is sampled on rising `sclk` edges, MSB first. The target register takes the new value after the last bit. A write to a read-only address consumes its length and changes nothing.
- R4: Read data changes only on falling `sclk` edges, MSB first, so each bit is valid at the following rising edge.
- R5: A `res_valid` pulse captures `res_data` unchanged (offset binary, MSB first when read) and drives the flag low.
- R6: The flag goes high once the last bit of a result-register read has been clocked.
- R7: An `upd_warn` pulse drives the flag high without a read. If `res_valid` arrives in the same cycle, it wins and the flag stays low.
- R8: Outside continuous mode, the result register can be read again while the flag is high and returns the same word. Reads of other registers leave the flag unchanged.
- R9: With `cs_n` low and no read shifting, `dout` equals the flag level.
- R10: A read of address 3 with bit 2 set completes normally and then enters continuous mode. In continuous mode, the first falling `sclk` edge while the flag is low starts a 24-bit result transfer with no command byte. Clocks that arrive while the flag is high are ignored. Each result is sent once.
- R11: 32 consecutive ones sampled on `din` return the port to waiting for a command byte and leave continuous mode. This works from any state and keeps all register contents.
- R12: After reset the mode register holds `MODE_RST`, the config register holds `CONF_RST`, and the flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Read data or active-low data-ready flag |
| dout_en | output | 1 | Output driver enable; low means high impedance |
| res_valid | input | 1 | One-cycle strobe for a new conversion result |
| res_data | input | DATA_W | Conversion result word |
| upd_warn | input | 1 | Pulse marking the approach of the next update |
| mode_q | output | REG_W | Mode register contents |
| conf_q | output | REG_W | Config register contents |

## Verification
Most internal faults show up as a loss of frame alignment. If the bit counter or the state slips, the next command byte is decoded from the wrong bits. The following register read then returns a shifted or wrong word within one access. A fault in the flag logic shows up on `dout` a few clocks after a strobe, a warning pulse or a completed result read, because the idle pin level follows the flag. A continuous-mode fault appears at the next 24-clock burst: either a result is sent twice or the burst is taken as a command.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2,
    ST_CRD = 2'd3
  } ser_state_e;

  localparam logic [2:0] ADDR_STAT = 3'd0;
  localparam logic [2:0] ADDR_MODE = 3'd1;
  localparam logic [2:0] ADDR_CONF = 3'd2;
  localparam logic [2:0] ADDR_DATA = 3'd3;

  // Number of bits moved after a command byte for a given address.
  function automatic int reg_bits(input logic [2:0] addr, input int reg_w, input int data_w);
    case (addr)
      ADDR_MODE, ADDR_CONF: return reg_w;
      ADDR_DATA:            return data_w;
      default:              return 8;
    endcase
  endfunction

endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic sel,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic din_s
);

  logic [STAGES-1:0] sclk_sh, cs_sh, din_sh;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sh <= '1;
      cs_sh   <= '1;
      din_sh  <= '0;
      sclk_d  <= 1'b1;
    end else begin
      sclk_sh <= {sclk_sh[STAGES-2:0], sclk};
      cs_sh   <= {cs_sh[STAGES-2:0], cs_n};
      din_sh  <= {din_sh[STAGES-2:0], din};
      sclk_d  <= sclk_sh[STAGES-1];
    end
  end

  assign sel       = ~cs_sh[STAGES-1];
  assign sclk_rise = sel &  sclk_sh[STAGES-1] & ~sclk_d;
  assign sclk_fall = sel & ~sclk_sh[STAGES-1] &  sclk_d;
  assign din_s     = din_sh[STAGES-1];

endmodule

// File: rtl/drdy_flag.sv
module drdy_flag #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              rd_done,
  input  logic              upd_warn,
  output logic              rdy_n,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n  <= 1'b1;
      data_q <= '0;
    end else if (res_valid) begin
      rdy_n  <= 1'b0;
      data_q <= res_data;
    end else if (rd_done || upd_warn) begin
      rdy_n  <= 1'b1;
    end
  end

  a_r5_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !rdy_n);
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (data_q == $past(res_data)));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !res_valid) |=> rdy_n);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !rd_done && !upd_warn) |=> $stable(rdy_n));

endmodule

// File: rtl/ser_frame_ctrl.sv
module ser_frame_ctrl
  import ser_reg_pkg::*;
#(
  parameter int          DATA_W     = 24,
  parameter int          REG_W      = 16,
  parameter logic [REG_W-1:0] MODE_RST = 16'h000A,
  parameter logic [REG_W-1:0] CONF_RST = 16'h0710,
  parameter int          ONES_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              din_s,
  input  logic              rdy_n,
  input  logic [DATA_W-1:0] data_q,
  output logic              tx_active,
  output logic              tx_bit,
  output logic              rd_done,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  conf_q
);

  localparam int SH_W   = (DATA_W > REG_W) ? DATA_W : REG_W;
  localparam int CNT_W  = $clog2(SH_W + 1);
  localparam int ONES_W = $clog2(ONES_LIMIT + 1);

  ser_state_e        state;
  logic [2:0]        addr_q;
  logic              cread_q;
  logic [CNT_W-1:0]  bitcnt, len_q;
  logic [SH_W-1:0]   shreg, rd_val, data_al;
  logic [REG_W-2:0]  rxsh;
  logic [ONES_W-1:0] ones_cnt;
  logic              tx_q;

  // Command fields as seen on the eighth rising edge (din_s is bit 0).
  logic       cmd_bad, cmd_rd, cmd_cr;
  logic [2:0] cmd_addr;
  logic [REG_W-1:0] wr_word;
  logic       last_bit, ones_hit, crd_start;

  assign cmd_bad  = rxsh[6];
  assign cmd_rd   = rxsh[5];
  assign cmd_addr = rxsh[4:2];
  assign cmd_cr   = rxsh[1];
  assign wr_word  = {rxsh, din_s};
  assign last_bit = (bitcnt == len_q - 1'b1);
  assign ones_hit = sclk_rise && din_s && (ones_cnt == ONES_W'(ONES_LIMIT - 1));
  assign crd_start = sclk_fall && (state == ST_CRD) && !rdy_n;
  assign data_al  = SH_W'(data_q) << (SH_W - DATA_W);

  always_comb begin
    case (cmd_addr)
      ADDR_STAT: rd_val = SH_W'({rdy_n, 7'b0}) << (SH_W - 8);
      ADDR_MODE: rd_val = SH_W'(mode_q) << (SH_W - REG_W);
      ADDR_CONF: rd_val = SH_W'(conf_q) << (SH_W - REG_W);
      ADDR_DATA: rd_val = data_al;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CMD;
      addr_q   <= '0;
      cread_q  <= 1'b0;
      bitcnt   <= '0;
      len_q    <= CNT_W'(8);
      shreg    <= '0;
      rxsh     <= '0;
      ones_cnt <= '0;
      tx_q     <= 1'b1;
      mode_q   <= MODE_RST;
      conf_q   <= CONF_RST;
    end else if (ones_hit) begin
      state    <= ST_CMD;
      cread_q  <= 1'b0;
      bitcnt   <= '0;
      ones_cnt <= '0;
    end else begin
      if (sclk_rise) begin
        ones_cnt <= din_s ? ones_cnt + 1'b1 : '0;
        rxsh     <= {rxsh[REG_W-3:0], din_s};
      end
      case (state)
        ST_CMD: if (sclk_rise) begin
          if (bitcnt == CNT_W'(7)) begin
            bitcnt <= '0;
            if (!cmd_bad) begin
              addr_q <= cmd_addr;
              len_q  <= CNT_W'(reg_bits(cmd_addr, REG_W, DATA_W));
              if (cmd_rd) begin
                state <= ST_RD;
                shreg <= rd_val;
                if (cmd_addr == ADDR_DATA && cmd_cr) cread_q <= 1'b1;
              end else begin
                state <= ST_WR;
              end
            end
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_WR: if (sclk_rise) begin
          if (last_bit) begin
            bitcnt <= '0;
            state  <= ST_CMD;
            if (addr_q == ADDR_MODE)      mode_q <= wr_word;
            else if (addr_q == ADDR_CONF) conf_q <= wr_word;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_RD: begin
          if (sclk_fall) begin
            tx_q  <= shreg[SH_W-1];
            shreg <= shreg << 1;
          end
          if (sclk_rise) begin
            if (last_bit) begin
              bitcnt <= '0;
              state  <= cread_q ? ST_CRD : ST_CMD;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_CRD: if (crd_start) begin
          tx_q   <= data_q[DATA_W-1];
          shreg  <= data_al << 1;
          addr_q <= ADDR_DATA;
          len_q  <= CNT_W'(DATA_W);
          bitcnt <= '0;
          state  <= ST_RD;
        end
        default: state <= ST_CMD;
      endcase
    end
  end

  assign tx_active = (state == ST_RD);
  assign tx_bit    = tx_q;
  assign rd_done   = sclk_rise && (state == ST_RD) && last_bit && (addr_q == ADDR_DATA);

  a_r4_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && sclk_rise) |-> (bitcnt < len_q));
  a_r10_crd_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CRD) |-> cread_q);
  a_r11_ones_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ones_hit |=> (state == ST_CMD && !cread_q && bitcnt == '0));
  a_r2_back_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR && sclk_rise && last_bit && !ones_hit) |=> (state == ST_CMD));

endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port #(
  parameter int          DATA_W      = 24,
  parameter int          REG_W       = 16,
  parameter logic [REG_W-1:0] MODE_RST = 16'h000A,
  parameter logic [REG_W-1:0] CONF_RST = 16'h0710,
  parameter int          SYNC_STAGES = 2,
  parameter int          ONES_LIMIT  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_en,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              upd_warn,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  conf_q
);

  logic sel, sclk_rise, sclk_fall, din_s;
  logic rdy_n, rd_done, tx_active, tx_bit;
  logic [DATA_W-1:0] data_q;

  ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sel(sel), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din_s(din_s)
  );

  drdy_flag #(.DATA_W(DATA_W)) u_flag (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .rd_done(rd_done), .upd_warn(upd_warn), .rdy_n(rdy_n), .data_q(data_q)
  );

  ser_frame_ctrl #(
    .DATA_W(DATA_W), .REG_W(REG_W), .MODE_RST(MODE_RST),
    .CONF_RST(CONF_RST), .ONES_LIMIT(ONES_LIMIT)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .din_s(din_s), .rdy_n(rdy_n), .data_q(data_q), .tx_active(tx_active),
    .tx_bit(tx_bit), .rd_done(rd_done), .mode_q(mode_q), .conf_q(conf_q)
  );

  assign dout_en = ~cs_n;
  assign dout    = tx_active ? tx_bit : rdy_n;

  a_r1_no_edges_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!sclk_rise && !sclk_fall));

endmodule

// File: tb/ser_reg_port_tb.sv
module ser_reg_port_tb;

  localparam int CLK_P = 10;
  localparam int HALF  = 6;
  localparam int WD    = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic        res_valid = 1'b0, upd_warn = 1'b0;
  logic [23:0] res_data = '0;
  logic        dout, dout_en;
  logic [15:0] mode_q, conf_q;

  int n_chk = 0, n_fail = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [15:0] exp_mode = 16'h000A, exp_conf = 16'h0710;
  logic        exp_rdy = 1'b1;
  logic [31:0] rx;

  always #(CLK_P/2) clk = ~clk;

  ser_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_en(dout_en), .res_valid(res_valid), .res_data(res_data),
    .upd_warn(upd_warn), .mode_q(mode_q), .conf_q(conf_q)
  );

  // Per-cycle comparison against the bench model (R9 idle level, R1 enable).
  always @(negedge clk) begin
    if (rst_n && quiet && !done) begin
      n_chk++;
      if (mode_q !== exp_mode || conf_q !== exp_conf || dout_en !== !cs_n ||
          (!cs_n && dout !== exp_rdy)) begin
        n_fail++;
        $display("FAIL R9 model: dout=%b/%b en=%b mode=%h/%h conf=%h/%h",
                 dout, exp_rdy, dout_en, mode_q, exp_mode, conf_q, exp_conf);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [31:0] tx, output logic [31:0] r);
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      sclk = 1'b0;
      din  = tx[i];
      repeat (HALF) @(negedge clk);
      r = {r[30:0], dout};
      sclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
    din = 1'b0;
  endtask

  task automatic wr_reg(input logic [2:0] a, input int n, input logic [31:0] v);
    logic [31:0] d;
    quiet = 0;
    xfer(8, {24'h0, 2'b00, a, 3'b000}, d);
    xfer(n, v, d);
    settle();
    if (a == 3'd1) exp_mode = v[15:0];
    if (a == 3'd2) exp_conf = v[15:0];
    quiet = 1;
  endtask

  task automatic rd_reg(input logic [2:0] a, input int n, input bit cr, output logic [31:0] r);
    logic [31:0] d;
    quiet = 0;
    xfer(8, {24'h0, 2'b01, a, cr, 2'b00}, d);
    xfer(n, 32'h0, r);
    settle();
    if (a == 3'd3) exp_rdy = 1'b1;
    quiet = 1;
  endtask

  task automatic crd_word(output logic [31:0] r);
    quiet = 0;
    xfer(24, 32'h0, r);
    settle();
    exp_rdy = 1'b1;
    quiet = 1;
  endtask

  task automatic strobe(input logic [23:0] v, input bit warn);
    quiet = 0;
    @(negedge clk);
    res_valid = 1'b1; res_data = v; upd_warn = warn;
    @(negedge clk);
    res_valid = 1'b0; upd_warn = 1'b0;
    settle();
    exp_rdy = 1'b0;
    quiet = 1;
  endtask

  task automatic warn_pulse();
    quiet = 0;
    @(negedge clk) upd_warn = 1'b1;
    @(negedge clk) upd_warn = 1'b0;
    settle();
    exp_rdy = 1'b1;
    quiet = 1;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD, WD);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk(dout_en == 1'b0, "R1 deselected enable", dout_en, 0);
    chk(mode_q == 16'h000A, "R12 mode reset", mode_q, 16'h000A);
    chk(conf_q == 16'h0710, "R12 conf reset", conf_q, 16'h0710);
    cs_n = 1'b0;
    settle();
    chk(dout == 1'b1, "R12 flag high after reset", dout, 1);
    quiet = 1;

    rd_reg(3'd1, 16, 0, rx);
    chk(rx[15:0] == 16'h000A, "R4 read mode reset", rx, 16'h000A);
    wr_reg(3'd1, 16, 32'h1234);
    chk(mode_q == 16'h1234, "R3 write mode", mode_q, 16'h1234);
    rd_reg(3'd1, 16, 0, rx);
    chk(rx[15:0] == 16'h1234, "R4 read mode", rx, 16'h1234);
    wr_reg(3'd2, 16, 32'hA5C3);
    rd_reg(3'd2, 16, 0, rx);
    chk(rx[15:0] == 16'hA5C3, "R3 config round trip", rx, 16'hA5C3);

    strobe(24'h800123, 0);
    chk(dout == 1'b0, "R5 flag low on result", dout, 0);
    rd_reg(3'd0, 8, 0, rx);
    chk(rx[7:0] == 8'h00, "R2 status shows low flag", rx, 8'h00);
    chk(dout == 1'b0, "R8 status read keeps flag", dout, 0);
    rd_reg(3'd3, 24, 0, rx);
    chk(rx[23:0] == 24'h800123, "R5 result word", rx, 24'h800123);
    chk(dout == 1'b1, "R6 flag high after read", dout, 1);
    rd_reg(3'd3, 24, 0, rx);
    chk(rx[23:0] == 24'h800123, "R8 re-read same word", rx, 24'h800123);
    rd_reg(3'd0, 8, 0, rx);
    chk(rx[7:0] == 8'h80, "R2 status shows high flag", rx, 8'h80);

    strobe(24'h00FF00, 0);
    warn_pulse();
    chk(dout == 1'b1, "R7 warning clears flag", dout, 1);
    rd_reg(3'd3, 24, 0, rx);
    chk(rx[23:0] == 24'h00FF00, "R8 word kept after warning", rx, 24'h00FF00);
    strobe(24'h3C3C3C, 1);
    chk(dout == 1'b0, "R7 strobe beats warning", dout, 0);
    rd_reg(3'd3, 24, 0, rx);
    chk(rx[23:0] == 24'h3C3C3C, "R5 word with warning", rx, 24'h3C3C3C);

    wr_reg(3'd3, 24, 32'h123456);
    wr_reg(3'd0, 8, 32'hFF);
    rd_reg(3'd3, 24, 0, rx);
    chk(rx[23:0] == 24'h3C3C3C, "R3 read-only write ignored", rx, 24'h3C3C3C);

    quiet = 0;
    xfer(8, 32'h88, d);
    quiet = 1;
    rd_reg(3'd1, 16, 0, rx);
    chk(rx[15:0] == 16'h1234, "R2 bad command discarded", rx, 16'h1234);
    rd_reg(3'd5, 8, 0, rx);
    chk(rx[7:0] == 8'h00, "R2 spare address reads zero", rx, 8'h00);
    rd_reg(3'd2, 16, 0, rx);
    chk(rx[15:0] == 16'hA5C3, "R2 alignment after spare", rx, 16'hA5C3);

    quiet = 0;
    cs_n = 1'b1;
    settle();
    chk(dout_en == 1'b0, "R1 high impedance", dout_en, 0);
    xfer(8, 32'h08, d);
    xfer(16, 32'hFFFF, d);
    cs_n = 1'b0;
    settle();
    quiet = 1;
    chk(mode_q == 16'h1234, "R1 clocks ignored while deselected", mode_q, 16'h1234);
    rd_reg(3'd1, 16, 0, rx);
    chk(rx[15:0] == 16'h1234, "R1 alignment kept", rx, 16'h1234);

    rd_reg(3'd3, 24, 1, rx);
    chk(rx[23:0] == 24'h3C3C3C, "R10 entry read", rx, 24'h3C3C3C);
    strobe(24'h7FFFFF, 0);
    chk(dout == 1'b0, "R10 flag low in continuous mode", dout, 0);
    crd_word(rx);
    chk(rx[23:0] == 24'h7FFFFF, "R10 word without command", rx, 24'h7FFFFF);
    chk(dout == 1'b1, "R10 flag high after word", dout, 1);
    crd_word(rx);
    chk(rx[23:0] == 24'hFFFFFF, "R10 no second copy", rx, 24'hFFFFFF);
    strobe(24'h000001, 0);
    crd_word(rx);
    chk(rx[23:0] == 24'h000001, "R10 next word aligned", rx, 24'h000001);

    quiet = 0;
    xfer(32, 32'hFFFFFFFF, d);
    settle();
    quiet = 1;
    strobe(24'h0ABCDE, 0);
    rd_reg(3'd1, 16, 0, rx);
    chk(rx[15:0] == 16'h1234, "R11 continuous mode left", rx, 16'h1234);
    chk(dout == 1'b0, "R11 flag survives exit", dout, 0);
    rd_reg(3'd3, 24, 0, rx);
    chk(rx[23:0] == 24'h0ABCDE, "R11 result kept", rx, 24'h0ABCDE);

    quiet = 0;
    xfer(3, 32'h2, d);
    xfer(32, 32'hFFFFFFFF, d);
    settle();
    quiet = 1;
    rd_reg(3'd2, 16, 0, rx);
    chk(rx[15:0] == 16'hA5C3, "R11 mid-frame realign", rx, 16'hA5C3);
    chk(mode_q == 16'h1234, "R11 registers kept", mode_q, 16'h1234);

    settle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule